// File: doc/BRIEF.md
# Instruction trace pin compressor

This block sits between a processor's execute stage and a handful of debug pins watched by an external logic analyzer. Each cycle it takes the program counter of the instruction in the execute stage together with that stage's valid strobe, keeps only the address bits that can change, and registers them onto the pins along with a forwarded clock and a valid pin. An instruction that is fetched but never executed never raises the strobe, so it never produces a trace entry.

Pins can be saved in two ways, both fixed at build time. The two low address bits are always dropped because instructions are word aligned. A parameter removes a chosen number of constant upper bits. In compressed mode, each data pin also carries two trace bits per clock: one while the clock is high and another while it is low.

To let the analyzer discover its wiring, a small command register can put the block into a training state. In that state one selected pin repeats a fixed 8-bit pattern while every other pin stays low. The analyzer then issues the command again for each pin in turn.

Top module: `trace_pin_compressor`

## Requirements
- R1: While `rst` is high at a rising edge, `pin_data` and `pin_valid` become 0 and training is turned off.
- R2: With training off, `pin_valid` after a rising edge equals the `ex_valid` value sampled at that edge. Instructions whose strobe is low produce no valid entry.
- R3: The trace word is `ex_pc[31-STATIC_HI:2]`, of width TRACE_W = 30 - STATIC_HI. Bits `ex_pc[1:0]` and the STATIC_HI top bits have no effect on any pin.
- R4: In flat mode (COMPRESS = 0) the width is OUT_W = TRACE_W. After each rising edge, `pin_data[i]` holds trace bit i of the value sampled at that edge.
- R5: In compressed mode (COMPRESS = 1) the width is OUT_W = ceil(TRACE_W/2). While `clk` is high, `pin_data[i]` is trace bit i. While `clk` is low, it is trace bit OUT_W+i. Both halves come from the word sampled at the preceding rising edge.
- R6: In compressed mode with an odd TRACE_W, the top pin carries 0 during the low phase.
- R7: `pin_clk` follows `clk`, and `pin_valid` holds the same value in both clock phases.
- R8: A command is written by pulsing `cfg_we`. In the command, `cfg_wdata[6]` is the enable and `cfg_wdata[5:0]` is the pin index. Index values below OUT_W select `pin_data[index]`, the value OUT_W selects `pin_valid`, and larger values select no pin.
- R9: After a write with the enable set, the selected pin shows 1,0,1,1,0,0,1,0 from the first edge that samples the write, one bit per clock and starting again every 8 clocks. In compressed mode the same bit appears in both phases.
- R10: While training is on, every pin except the selected one is 0, and the trace input is ignored.
- R11: A new enabled write during training switches to the new index at once and restarts the pattern at its first bit.
- R12: A write with the enable clear returns every pin to normal trace output from the edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_pc | input | 32 | Execute-stage program counter |
| ex_valid | input | 1 | Execute-stage instruction valid strobe |
| cfg_we | input | 1 | Command write strobe |
| cfg_wdata | input | 7 | Command: bit 6 enable, bits 5:0 pin index |
| pin_data | output | OUT_W | Trace address pins |
| pin_valid | output | 1 | Trace valid pin |
| pin_clk | output | 1 | Forwarded clock pin |

## Verification
The hardest case to reach from the ports is a training command that lands in the middle of a running pattern. The pattern must then switch pins and restart at its first bit, rather than continue from the bit counter's old position. The stimulus reaches this with directed rewrites at chosen offsets inside the 8-cycle sequence, and with random commands spread through a long random trace run. Some of those random commands carry indices above the valid pin, and some clear the enable. The bench runs three builds side by side: compressed with an even width, compressed with an odd width, and flat. This covers the odd padding bit and checks both clock phases against the same expected word.

// File: rtl/tpc_pkg.sv
`timescale 1ns/1ps
package tpc_pkg;
  localparam int CMD_W = 7;
  localparam int IDX_W = 6;
  localparam int SEQ_LEN = 8;
  localparam int SEQ_CNT_W = $clog2(SEQ_LEN);
  localparam logic [SEQ_LEN-1:0] TRAIN_SEQ = 8'b1011_0010;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
  } tpc_cmd_t;
endpackage

// File: rtl/tpc_ctrl.sv
`timescale 1ns/1ps
// Command register and training bit sequencer. Outputs next-state values so
// a command takes effect on the pins at the same edge that samples it.
module tpc_ctrl
  import tpc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CMD_W-1:0]     cfg_wdata,
  output logic                 train_d,
  output logic [IDX_W-1:0]     idx_d,
  output logic                 bit_d
);
  tpc_cmd_t               cmd;
  logic                   train_q;
  logic [IDX_W-1:0]       idx_q;
  logic [SEQ_CNT_W-1:0]   cnt_q;
  logic [SEQ_CNT_W-1:0]   cnt_d;

  assign cmd = tpc_cmd_t'(cfg_wdata);

  always_comb begin
    train_d = train_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    if (cfg_we) begin
      train_d = cmd.en;
      idx_d   = cmd.idx;
      cnt_d   = '0;
    end else if (train_q) begin
      cnt_d = cnt_q + 1'b1;
    end
    // MSB of the sequence goes out first.
    bit_d = TRAIN_SEQ[~cnt_d];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      train_q <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      train_q <= train_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/tpc_fold.sv
`timescale 1ns/1ps
// Selects the traced address bits and splits them into high- and low-phase words.
module tpc_fold #(
  parameter int STATIC_HI = 12,
  parameter bit COMPRESS  = 1'b1,
  localparam int TRACE_W  = 30 - STATIC_HI,
  localparam int OUT_W    = COMPRESS ? (TRACE_W + 1) / 2 : TRACE_W
) (
  input  logic [TRACE_W-1:0] trace,
  output logic [OUT_W-1:0]   hi_word,
  output logic [OUT_W-1:0]   lo_word
);
  assign hi_word = trace[OUT_W-1:0];

  generate
    if (COMPRESS) begin : g_fold
      for (genvar i = 0; i < OUT_W; i++) begin : g_lo
        if (OUT_W + i < TRACE_W) begin : g_bit
          assign lo_word[i] = trace[OUT_W + i];
        end else begin : g_pad
          assign lo_word[i] = 1'b0;
        end
      end
    end else begin : g_flat
      assign lo_word = '0;
    end
  endgenerate
endmodule

// File: rtl/tpc_shape.sv
`timescale 1ns/1ps
// Chooses between trace data and the training overlay for every pin.
module tpc_shape
  import tpc_pkg::*;
#(
  parameter int OUT_W = 9
) (
  input  logic               train,
  input  logic [IDX_W-1:0]   idx,
  input  logic               seq_bit,
  input  logic [OUT_W-1:0]   hi_word,
  input  logic [OUT_W-1:0]   lo_word,
  input  logic               ex_valid,
  output logic [OUT_W-1:0]   hi_d,
  output logic [OUT_W-1:0]   lo_d,
  output logic               valid_d
);
  generate
    for (genvar i = 0; i < OUT_W; i++) begin : g_pin
      logic sel;
      assign sel     = (idx == IDX_W'(i));
      assign hi_d[i] = train ? (sel & seq_bit) : hi_word[i];
      assign lo_d[i] = train ? (sel & seq_bit) : lo_word[i];
    end
  endgenerate

  assign valid_d = train ? ((idx == IDX_W'(OUT_W)) & seq_bit) : ex_valid;
endmodule

// File: rtl/tpc_outreg.sv
`timescale 1ns/1ps
// Pin registers; in compressed mode the clock level picks the phase word.
module tpc_outreg #(
  parameter int OUT_W    = 9,
  parameter bit COMPRESS = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OUT_W-1:0] hi_d,
  input  logic [OUT_W-1:0] lo_d,
  input  logic             valid_d,
  output logic [OUT_W-1:0] hi_q,
  output logic [OUT_W-1:0] lo_q,
  output logic [OUT_W-1:0] pin_data,
  output logic             pin_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      pin_valid <= 1'b0;
    end else begin
      hi_q      <= hi_d;
      pin_valid <= valid_d;
    end
  end

  generate
    if (COMPRESS) begin : g_dual
      always_ff @(posedge clk) begin
        if (rst) lo_q <= '0;
        else     lo_q <= lo_d;
      end
      assign pin_data = clk ? hi_q : lo_q;
    end else begin : g_single
      logic unused_lo_d;
      assign unused_lo_d = ^lo_d;
      assign lo_q        = '0;
      assign pin_data    = hi_q;
    end
  endgenerate
endmodule

// File: rtl/trace_pin_compressor.sv
`timescale 1ns/1ps
module trace_pin_compressor
  import tpc_pkg::*;
#(
  parameter int STATIC_HI = 12,
  parameter bit COMPRESS  = 1'b1,
  localparam int TRACE_W  = 30 - STATIC_HI,
  localparam int OUT_W    = COMPRESS ? (TRACE_W + 1) / 2 : TRACE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       ex_pc,
  input  logic              ex_valid,
  input  logic              cfg_we,
  input  logic [CMD_W-1:0]  cfg_wdata,
  output logic [OUT_W-1:0]  pin_data,
  output logic              pin_valid,
  output logic              pin_clk
);
  localparam logic [31:0] KEEP_MASK = ((32'h1 << TRACE_W) - 32'h1) << 2;

  logic [TRACE_W-1:0] trace;
  logic               unused_pc_bits;
  logic               train_d;
  logic [IDX_W-1:0]   idx_d;
  logic               bit_d;
  logic [OUT_W-1:0]   hi_word, lo_word, hi_d, lo_d, hi_q, lo_q;
  logic               valid_d;

  assign trace          = ex_pc[TRACE_W+1:2];
  assign unused_pc_bits = ^(ex_pc & ~KEEP_MASK);
  assign pin_clk        = clk;

  tpc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .train_d   (train_d),
    .idx_d     (idx_d),
    .bit_d     (bit_d)
  );

  tpc_fold #(.STATIC_HI(STATIC_HI), .COMPRESS(COMPRESS)) u_fold (
    .trace   (trace),
    .hi_word (hi_word),
    .lo_word (lo_word)
  );

  tpc_shape #(.OUT_W(OUT_W)) u_shape (
    .train    (train_d),
    .idx      (idx_d),
    .seq_bit  (bit_d),
    .hi_word  (hi_word),
    .lo_word  (lo_word),
    .ex_valid (ex_valid),
    .hi_d     (hi_d),
    .lo_d     (lo_d),
    .valid_d  (valid_d)
  );

  tpc_outreg #(.OUT_W(OUT_W), .COMPRESS(COMPRESS)) u_out (
    .clk       (clk),
    .rst       (rst),
    .hi_d      (hi_d),
    .lo_d      (lo_d),
    .valid_d   (valid_d),
    .hi_q      (hi_q),
    .lo_q      (lo_q),
    .pin_data  (pin_data),
    .pin_valid (pin_valid)
  );
endmodule

// File: rtl/tpc_checker.sv
`timescale 1ns/1ps
module tpc_checker #(
  parameter int OUT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [31:0]      ex_pc,
  input logic             ex_valid,
  input logic             cfg_we,
  input logic [6:0]       cfg_wdata,
  input logic [OUT_W-1:0] hi_q,
  input logic [OUT_W-1:0] lo_q,
  input logic             pin_valid
);
  logic tr_on;
  logic tr_next;

  assign tr_next = cfg_we ? cfg_wdata[6] : tr_on;

  always_ff @(posedge clk) begin
    if (rst) tr_on <= 1'b0;
    else     tr_on <= tr_next;
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !tr_next |=> pin_valid == $past(ex_valid));

  p_trace_word_r4: assert property (@(posedge clk) disable iff (rst)
    !tr_next |=> hi_q == $past(ex_pc[2 +: OUT_W]));

  p_hi_single_r10: assert property (@(posedge clk) disable iff (rst)
    tr_next |=> $onehot0({hi_q, pin_valid}));

  p_lo_single_r10: assert property (@(posedge clk) disable iff (rst)
    tr_next |=> $onehot0({lo_q, pin_valid}));

  p_first_bit_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_wdata[6]) |=>
      $countones({hi_q, pin_valid}) == (($past(cfg_wdata[5:0]) <= 6'(OUT_W)) ? 1 : 0));
endmodule

bind trace_pin_compressor tpc_checker #(.OUT_W(OUT_W)) u_tpc_checker (
  .clk       (clk),
  .rst       (rst),
  .ex_pc     (ex_pc),
  .ex_valid  (ex_valid),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .hi_q      (hi_q),
  .lo_q      (lo_q),
  .pin_valid (pin_valid)
);

// File: tb/test_trace_pin_compressor.sv
`timescale 1ns/1ps
module test_trace_pin_compressor;
  localparam logic [7:0] SEQ = 8'b1011_0010;
  // Build A: compressed, even width; B: flat; C: compressed, odd width.
  localparam int TW_A = 18, OW_A = 9;
  localparam int TW_B = 18, OW_B = 18;
  localparam int TW_C = 17, OW_C = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ex_pc = '0;
  logic        ex_valid = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_wdata = '0;

  logic [OW_A-1:0] pd_a;
  logic [OW_B-1:0] pd_b;
  logic [OW_C-1:0] pd_c;
  logic pv_a, pv_b, pv_c, pc_a, pc_b, pc_c;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // model state
  bit       m_on;
  int       m_idx;
  int       m_cnt;
  bit       m_bit;
  logic [31:0] m_pc;
  bit       m_v;

  always #2.5 clk = ~clk;

  trace_pin_compressor #(.STATIC_HI(12), .COMPRESS(1'b1)) i_trace_pin_compressor (
    .clk(clk), .rst(rst), .ex_pc(ex_pc), .ex_valid(ex_valid), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .pin_data(pd_a), .pin_valid(pv_a), .pin_clk(pc_a));

  trace_pin_compressor #(.STATIC_HI(12), .COMPRESS(1'b0)) i_trace_pin_compressor_flat (
    .clk(clk), .rst(rst), .ex_pc(ex_pc), .ex_valid(ex_valid), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .pin_data(pd_b), .pin_valid(pv_b), .pin_clk(pc_b));

  trace_pin_compressor #(.STATIC_HI(13), .COMPRESS(1'b1)) i_trace_pin_compressor_odd (
    .clk(clk), .rst(rst), .ex_pc(ex_pc), .ex_valid(ex_valid), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .pin_data(pd_c), .pin_valid(pv_c), .pin_clk(pc_c));

  function automatic logic [31:0] mask_of(input int w);
    return (32'h1 << w) - 32'h1;
  endfunction

  function automatic logic [31:0] exp_hi(input int ow);
    if (m_on) return (m_idx < ow) ? (32'(m_bit) << m_idx) : 32'h0;
    return (m_pc >> 2) & mask_of(ow);
  endfunction

  function automatic logic [31:0] exp_lo(input int tw, input int ow);
    if (m_on) return (m_idx < ow) ? (32'(m_bit) << m_idx) : 32'h0;
    return (m_pc >> (2 + ow)) & mask_of(tw - ow);
  endfunction

  function automatic logic exp_valid(input int ow);
    if (m_on) return (m_idx == ow) && m_bit;
    return m_v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic string tag_for(input string trace_tag);
    return m_on ? "R9" : trace_tag;
  endfunction

  // One clock: model the edge, then check high and low phases.
  task automatic step();
    @(posedge clk);
    if (rst) begin
      m_on = 1'b0; m_idx = 0; m_cnt = 0; m_pc = '0; m_v = 1'b0;
    end else begin
      if (cfg_we) begin
        m_on = cfg_wdata[6]; m_idx = int'(cfg_wdata[5:0]); m_cnt = 0;
      end else if (m_on) begin
        m_cnt = (m_cnt + 1) % 8;
      end
      m_pc = ex_pc; m_v = ex_valid;
    end
    m_bit = SEQ[7 - m_cnt];
    #1;
    if (!rst) begin
      check(tag_for("R5"), 32'(pd_a), exp_hi(OW_A));
      check(tag_for("R4"), 32'(pd_b), exp_hi(OW_B));
      check(tag_for("R5"), 32'(pd_c), exp_hi(OW_C));
      check(tag_for("R2"), 32'(pv_a), 32'(exp_valid(OW_A)));
      check(tag_for("R2"), 32'(pv_b), 32'(exp_valid(OW_B)));
      check(tag_for("R2"), 32'(pv_c), 32'(exp_valid(OW_C)));
      check("R7", 32'(pc_a), 32'h1);
    end
    @(negedge clk);
    #1;
    if (!rst) begin
      check(tag_for("R5"), 32'(pd_a), exp_lo(TW_A, OW_A));
      check(tag_for("R5"), 32'(pd_c), exp_lo(TW_C, OW_C));
      // R6: padded top pin of the odd build is 0 in the low phase
      if (!m_on) check("R6", 32'(pd_c[OW_C-1]), 32'h0);
      check("R7", 32'(pv_a), 32'(exp_valid(OW_A)));
      check("R7", 32'(pc_a), 32'h0);
    end
  endtask

  task automatic cmd(input bit en, input int idx);
    cfg_we = 1'b1; cfg_wdata = {en, 6'(idx)};
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_7A11));
    rst = 1'b1;
    ex_pc = 32'hFFFF_FFFF; ex_valid = 1'b1;
    step(); step();
    // R1: reset state of every pin
    check("R1", 32'(pd_a), 0); check("R1", 32'(pd_b), 0); check("R1", 32'(pd_c), 0);
    check("R1", 32'(pv_a), 0); check("R1", 32'(pv_b), 0);
    rst = 1'b0;
    ex_pc = '0; ex_valid = 1'b0;
    step();

    // R3: only the middle bits are traced; try extremes of upper and low bits
    ex_pc = 32'hFFF0_0003; ex_valid = 1'b1; step();
    ex_pc = 32'h000F_FFFC; ex_valid = 1'b1; step();
    ex_pc = 32'hAAAA_AAAA; ex_valid = 1'b0; step();   // R2 invalid entry
    ex_pc = 32'h5555_5555; ex_valid = 1'b1; step();

    // R8/R9: train the valid pin for longer than two pattern periods
    cmd(1'b1, OW_A);
    for (int i = 0; i < 17; i++) begin
      ex_pc = $urandom; ex_valid = 1'(i); step();   // R10: trace ignored
    end
    // R11: restart mid-pattern on a data pin
    cmd(1'b1, 3);
    for (int i = 0; i < 5; i++) step();
    cmd(1'b1, 8);
    for (int i = 0; i < 10; i++) step();
    // R8: index beyond every pin drives nothing
    cmd(1'b1, 63);
    for (int i = 0; i < 4; i++) step();
    // R12: disable returns trace output at once
    ex_pc = 32'h0001_2344; ex_valid = 1'b1;
    cmd(1'b0, 0);
    step();

    // random trace mixed with random commands
    for (int n = 0; n < 400; n++) begin
      ex_pc    = $urandom;
      ex_valid = 1'($urandom);
      if ($urandom_range(0, 19) == 0) begin
        cfg_we    = 1'b1;
        cfg_wdata = {1'($urandom_range(0, 2) != 0), 6'($urandom_range(0, 21))};
      end
      step();
      cfg_we = 1'b0;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule